// File: doc/BRIEF.md
# Thread State Aggregation Decoder

This block condenses a 64-bit per-core status word into an eight-flag state vector that describes a chosen group of hardware threads. A thread-select mask names the threads of interest. Each thread owns a fixed-width lane of the status word. Inside each lane the block picks out five status fields: maintenance, quiesced, instruction-completion-table empty, load/store quiesced and step success.

Per-thread values are then combined in two ways. Some flags report a condition that at least one selected thread meets. Others report a condition that every selected thread meets. Running and stopped are both built from the maintenance and quiesced fields. Stopped is evaluated only when running is false, so the two flags never appear together.

A parameter selects the output variant. One variant is a purely combinational path. The other is a registered stage that loads on an input valid strobe and raises an output valid strobe one cycle later. Callers use the vector to decide whether a start, stop or single-step action on the selected threads makes sense.

Top module: `thread_state_agg`

## Requirements
- R1: Mask bit `thread_sel[NUM_THREADS-1-t]` selects thread t, so the most significant mask bit selects thread 0. Thread t's lane occupies status bits `[63-8t : 56-8t]`. A field at offset k inside a lane sits at word bit `63-8t-k`. Default offsets are maintenance 0, quiesced 1, ICT-empty 2, load/store-quiesced 3 and step-success 4.
- R2: `state_vec[0]` (running) is 1 exactly when no selected thread has its maintenance bit or its quiesced bit set.
- R3: `state_vec[1]` (stopped) is 1 exactly when running is 0 and every selected thread has both maintenance and quiesced set. Running and stopped are never 1 together.
- R4: Each of `state_vec[2]` (maintenance), `[3]` (quiesced), `[4]` (ICT-empty), `[5]` (load/store-quiesced) and `[6]` (step-success) is 1 when at least one selected thread has that field set.
- R5: `state_vec[7]` (step-ready) is 1 exactly when every selected thread has maintenance, quiesced and ICT-empty all set.
- R6: With an all-zero mask the vector is `8'h81`, whatever the status word holds. Running and step-ready are 1 and every other flag is 0.
- R7: Bits in the lanes of unselected threads have no effect on the vector.
- R8: With `REG_OUT=1` the vector is loaded at the clock edge on which `in_valid` is 1 and appears after that edge. `state_valid` is `in_valid` delayed by one cycle. When `in_valid` is 0 the vector holds its value.
- R9: With `REG_OUT=1`, a clock edge with `rst_n` low clears `state_vec` to 0 and `state_valid` to 0.
- R10: With `REG_OUT=0` the vector follows the inputs in the same cycle and `state_valid` equals `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered stage |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks the current status word and mask as meaningful |
| status_word | input | 64 | Per-core status, one 8-bit lane per thread, thread 0 in the top lane |
| thread_sel | input | 4 | Thread-select mask, MSB selects thread 0 |
| state_vec | output | 8 | Aggregated flags: run, stop, maint, quiesced, ICT-empty, LSU-quiesced, step-success, step-ready (bit 0 upward) |
| state_valid | output | 1 | Marks `state_vec` as meaningful |

## Verification
The bench builds two copies with the default field offsets and four 8-bit lanes. Instance `u0` has the registered stage, and instance `u1` is purely combinational. Both receive the same stimulus, which brings into reach the one-cycle latency, the hold on idle cycles and the reset clearing, next to a same-cycle reference for every flag. Status words are assembled lane by lane from biased patterns: all fields clear, maintenance and quiesced set, step-ready fields set, and random. As a result, the every-thread reductions (stopped, step-ready) fire often, not only by chance.

// File: rtl/tsa_pkg.sv
// Package: shared flag positions and lane field type for the thread
// state aggregation decoder. Assumes an eight-flag output vector.
package tsa_pkg;

    localparam int NUM_FLAGS    = 8;
    localparam int FLAG_RUN     = 0;
    localparam int FLAG_STOP    = 1;
    localparam int FLAG_MAINT   = 2;
    localparam int FLAG_QUIES   = 3;
    localparam int FLAG_ICTE    = 4;
    localparam int FLAG_LSUQ    = 5;
    localparam int FLAG_STEPOK  = 6;
    localparam int FLAG_STEPRDY = 7;

    typedef logic [NUM_FLAGS-1:0] tstate_t;

    typedef struct packed {
        logic stepok;
        logic lsuq;
        logic icte;
        logic quies;
        logic maint;
    } lane_fields_t;

endpackage

// File: rtl/tsa_lane_extract.sv
// Module: pulls the five status fields out of one thread's lane.
// Assumes offsets are counted from the lane MSB and are below STRIDE.
module tsa_lane_extract
    import tsa_pkg::*;
#(
    parameter int STRIDE     = 8,
    parameter int MAINT_OFS  = 0,
    parameter int QUIES_OFS  = 1,
    parameter int ICTE_OFS   = 2,
    parameter int LSUQ_OFS   = 3,
    parameter int STEPOK_OFS = 4
) (
    input  logic [STRIDE-1:0] lane,
    output lane_fields_t      fields
);

    localparam int TOP = STRIDE - 1;

    // Lane bits outside the five fields are intentionally ignored.
    logic unused_lane_bits;
    assign unused_lane_bits = ^lane;

    // Map MSB-relative offsets onto lane bit positions.
    always_comb begin
        fields.maint  = lane[TOP - MAINT_OFS];
        fields.quies  = lane[TOP - QUIES_OFS];
        fields.icte   = lane[TOP - ICTE_OFS];
        fields.lsuq   = lane[TOP - LSUQ_OFS];
        fields.stepok = lane[TOP - STEPOK_OFS];
    end

endmodule

// File: rtl/tsa_reduce.sv
// Module: combines per-thread fields of the selected threads into the
// flag vector. Any-of flags use OR reductions; every-thread flags use
// AND reductions in which unselected threads count as satisfied.
// Assumes vectors are indexed by thread number.
module tsa_reduce
    import tsa_pkg::*;
#(
    parameter int NUM_THREADS = 4
) (
    input  logic [NUM_THREADS-1:0] sel,
    input  logic [NUM_THREADS-1:0] maint,
    input  logic [NUM_THREADS-1:0] quies,
    input  logic [NUM_THREADS-1:0] icte,
    input  logic [NUM_THREADS-1:0] lsuq,
    input  logic [NUM_THREADS-1:0] stepok,
    output tstate_t                flags
);

    logic [NUM_THREADS-1:0] hit_maint, hit_quies, hit_icte;
    logic [NUM_THREADS-1:0] hit_lsuq, hit_stepok;
    logic [NUM_THREADS-1:0] ok_both, ok_ready;
    logic                   none_busy, all_both, all_ready;

    // Per-thread gating by the select mask.
    always_comb begin
        hit_maint  = sel & maint;
        hit_quies  = sel & quies;
        hit_icte   = sel & icte;
        hit_lsuq   = sel & lsuq;
        hit_stepok = sel & stepok;
        ok_both    = ~sel | (maint & quies);
        ok_ready   = ~sel | (maint & quies & icte);
    end

    // Group reductions and the run/stop priority.
    always_comb begin
        none_busy = ~|(hit_maint | hit_quies);
        all_both  = &ok_both;
        all_ready = &ok_ready;

        flags               = '0;
        flags[FLAG_RUN]     = none_busy;
        flags[FLAG_STOP]    = !none_busy && all_both;
        flags[FLAG_MAINT]   = |hit_maint;
        flags[FLAG_QUIES]   = |hit_quies;
        flags[FLAG_ICTE]    = |hit_icte;
        flags[FLAG_LSUQ]    = |hit_lsuq;
        flags[FLAG_STEPOK]  = |hit_stepok;
        flags[FLAG_STEPRDY] = all_ready;
    end

endmodule

// File: rtl/tsa_out_stage.sv
// Module: optional output register with valid strobe. REG_OUT=1 loads on
// in_valid and delays valid by one cycle; REG_OUT=0 passes through.
// Assumes synchronous active-low reset.
module tsa_out_stage #(
    parameter int REG_OUT = 1,
    parameter int W       = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         q_valid
);

    generate
        if (REG_OUT != 0) begin : g_reg
            logic [W-1:0] q_r;
            logic         v_r;

            // Capture flags on valid input; track valid one cycle late.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q_r <= '0;
                    v_r <= 1'b0;
                end else begin
                    if (in_valid) begin
                        q_r <= d;
                    end
                    v_r <= in_valid;
                end
            end

            assign q       = q_r;
            assign q_valid = v_r;
        end else begin : g_comb
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst_n;

            assign q       = d;
            assign q_valid = in_valid;
        end
    endgenerate

endmodule

// File: rtl/thread_state_agg.sv
// Module: top of the thread state aggregation decoder. Slices the status
// word into per-thread lanes, reorders the MSB-first mask into thread
// order, reduces and optionally registers the result.
// Assumes NUM_THREADS*LANE_STRIDE <= WORD_W and lane offsets < LANE_STRIDE.
module thread_state_agg
    import tsa_pkg::*;
#(
    parameter int WORD_W      = 64,
    parameter int NUM_THREADS = 4,
    parameter int LANE_STRIDE = 8,
    parameter int MAINT_OFS   = 0,
    parameter int QUIES_OFS   = 1,
    parameter int ICTE_OFS    = 2,
    parameter int LSUQ_OFS    = 3,
    parameter int STEPOK_OFS  = 4,
    parameter int REG_OUT     = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [WORD_W-1:0]      status_word,
    input  logic [NUM_THREADS-1:0] thread_sel,
    output logic [NUM_FLAGS-1:0]   state_vec,
    output logic                   state_valid
);

    localparam int USED_W = NUM_THREADS * LANE_STRIDE;

    logic [NUM_THREADS-1:0] sel_t;
    logic [NUM_THREADS-1:0] f_maint, f_quies, f_icte, f_lsuq, f_stepok;
    tstate_t                flags;

    generate
        if (USED_W < WORD_W) begin : g_spare
            logic unused_spare_bits;
            assign unused_spare_bits = ^status_word[WORD_W-USED_W-1:0];
        end

        for (genvar t = 0; t < NUM_THREADS; t++) begin : g_lane
            lane_fields_t fld;

            // Mask MSB belongs to thread 0.
            assign sel_t[t] = thread_sel[NUM_THREADS-1-t];

            tsa_lane_extract #(
                .STRIDE     (LANE_STRIDE),
                .MAINT_OFS  (MAINT_OFS),
                .QUIES_OFS  (QUIES_OFS),
                .ICTE_OFS   (ICTE_OFS),
                .LSUQ_OFS   (LSUQ_OFS),
                .STEPOK_OFS (STEPOK_OFS)
            ) u_lane (
                .lane   (status_word[WORD_W-1-t*LANE_STRIDE -: LANE_STRIDE]),
                .fields (fld)
            );

            assign f_maint[t]  = fld.maint;
            assign f_quies[t]  = fld.quies;
            assign f_icte[t]   = fld.icte;
            assign f_lsuq[t]   = fld.lsuq;
            assign f_stepok[t] = fld.stepok;
        end
    endgenerate

    tsa_reduce #(
        .NUM_THREADS (NUM_THREADS)
    ) u_reduce (
        .sel    (sel_t),
        .maint  (f_maint),
        .quies  (f_quies),
        .icte   (f_icte),
        .lsuq   (f_lsuq),
        .stepok (f_stepok),
        .flags  (flags)
    );

    tsa_out_stage #(
        .REG_OUT (REG_OUT),
        .W       (NUM_FLAGS)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .d        (flags),
        .q        (state_vec),
        .q_valid  (state_valid)
    );

endmodule

// File: rtl/thread_state_agg_chk.sv
// Checker: temporal and cross-flag properties of the decoder outputs.
// Assumes it is bound to thread_state_agg with the same REG_OUT.
module thread_state_agg_chk
    import tsa_pkg::*;
#(
    parameter int REG_OUT = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [NUM_FLAGS-1:0] state_vec,
    input logic                 state_valid
);

    // R3
    run_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_vec[FLAG_RUN] && state_vec[FLAG_STOP]));

    // R2
    run_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_vec[FLAG_RUN] |-> (!state_vec[FLAG_MAINT] && !state_vec[FLAG_QUIES]));

    // R3
    stop_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_vec[FLAG_STOP] |-> (state_vec[FLAG_MAINT] && state_vec[FLAG_QUIES]));

    // R5
    ready_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_vec[FLAG_STEPRDY] && !state_vec[FLAG_RUN]) |->
        (state_vec[FLAG_MAINT] && state_vec[FLAG_QUIES] && state_vec[FLAG_ICTE]));

    generate
        if (REG_OUT != 0) begin : g_reg_chk
            // R8
            valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> state_valid);

            // R8
            idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> (!state_valid && $stable(state_vec)));

            // R9
            reset_clear_chk: assert property (@(posedge clk)
                !rst_n |=> (state_vec == '0 && !state_valid));
        end
    endgenerate

endmodule

bind thread_state_agg thread_state_agg_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .state_vec   (state_vec),
    .state_valid (state_valid)
);

// File: tb/sim_thread_state_agg.sv
`timescale 1ns/1ps
module sim_thread_state_agg;

    localparam int OFS_M = 0, OFS_Q = 1, OFS_I = 2, OFS_L = 3, OFS_S = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] status_word = '0;
    logic [3:0]  thread_sel = '0;
    logic [7:0]  vec_r, vec_c;
    logic        val_r, val_c;

    int checks = 0;
    int fails  = 0;

    logic [7:0] exp_reg = '0;
    logic       exp_vld = 1'b0;

    always #2.5 clk = ~clk;

    thread_state_agg #(.REG_OUT(1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .status_word(status_word), .thread_sel(thread_sel),
        .state_vec(vec_r), .state_valid(val_r));

    thread_state_agg #(.REG_OUT(0)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .status_word(status_word), .thread_sel(thread_sel),
        .state_vec(vec_c), .state_valid(val_c));

    // Behavioural reference: count threads meeting each condition.
    function automatic logic [7:0] ref_state(input logic [63:0] w, input logic [3:0] s);
        int n_sel = 0, n_both = 0, n_busy = 0, n_rdy = 0;
        int n_m = 0, n_q = 0, n_i = 0, n_l = 0, n_s = 0;
        logic [7:0] r = '0;
        for (int t = 0; t < 4; t++) begin
            if (s[3-t]) begin
                int base = 63 - 8*t;
                logic m = w[base-OFS_M];
                logic q = w[base-OFS_Q];
                logic i = w[base-OFS_I];
                n_sel++;
                if (m) n_m++;
                if (q) n_q++;
                if (i) n_i++;
                if (w[base-OFS_L]) n_l++;
                if (w[base-OFS_S]) n_s++;
                if (m || q) n_busy++;
                if (m && q) n_both++;
                if (m && q && i) n_rdy++;
            end
        end
        r[0] = (n_busy == 0);
        r[1] = !r[0] && (n_both == n_sel);
        r[2] = n_m > 0;
        r[3] = n_q > 0;
        r[4] = n_i > 0;
        r[5] = n_l > 0;
        r[6] = n_s > 0;
        r[7] = (n_rdy == n_sel);
        return r;
    endfunction

    // Lane pattern: 0 random, 1 all clear, 2 maint+quies, 3 step-ready, 4 step-ok only.
    function automatic logic [7:0] make_lane(input int mode);
        logic [7:0] l = 8'($urandom);
        case (mode)
            1: l = l & 8'h07;
            2: l = (l & 8'hdf) | 8'hc0;
            3: l = l | 8'he0;
            4: l = (l & 8'h07) | 8'h08;
            default: ;
        endcase
        return l;
    endfunction

    function automatic logic [63:0] make_word(input int m0, m1, m2, m3);
        return {make_lane(m0), make_lane(m1), make_lane(m2), make_lane(m3), 32'($urandom)};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string bit_tag(input int b);
        case (b)
            0: return "R2 running";
            1: return "R3 stopped";
            7: return "R5 step-ready";
            default: return $sformatf("R4 any-of bit%0d", b);
        endcase
    endfunction

    task automatic cmp_vec(input string who, input logic [7:0] act, input logic [7:0] exp);
        for (int b = 0; b < 8; b++) check({who, " ", bit_tag(b)}, 8'(act[b]), 8'(exp[b]));
    endtask

    // One cycle: check registered copy, drive, check combinational copy.
    task automatic apply(input logic [63:0] w, input logic [3:0] s, input logic v);
        logic [7:0] e;
        @(negedge clk);
        cmp_vec("R8 reg", vec_r, exp_reg);
        check("R8 reg valid", 8'(val_r), 8'(exp_vld));
        status_word = w;
        thread_sel  = s;
        in_valid    = v;
        #1;
        e = ref_state(w, s);
        cmp_vec("R10 comb", vec_c, e);
        check("R10 comb valid", 8'(val_c), 8'(v));
        if (v) exp_reg = e;
        exp_vld = v;
    endtask

    initial begin : watchdog
        #(5 * 150000);
        checks++;
        fails++;
        $display("FAIL R8 watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : stim
        logic [63:0] w;
        logic [7:0]  first;
        status_word = 64'hffff_ffff_ffff_ffff;
        in_valid    = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset clears registered outputs
        check("R9 reset vec", vec_r, 8'h00);
        check("R9 reset valid", 8'(val_r), 8'h00);
        in_valid = 1'b0;
        rst_n    = 1'b1;

        // R1 single-thread selection maps MSB to thread 0
        for (int t = 0; t < 4; t++) begin
            w = 64'd1 << (63 - 8*t - OFS_M);
            apply(w, 4'(4'b1000 >> t), 1'b1);
            check($sformatf("R1 own maint t%0d", t), 8'(vec_c[2]), 8'h01);
            apply(w, 4'((4'b1000 >> t) ^ 4'b1111), 1'b1);
            check($sformatf("R1 other maint t%0d", t), 8'(vec_c[2]), 8'h00);
        end

        // R6 empty mask
        apply(64'hffff_ffff_ffff_ffff, 4'b0000, 1'b1);
        check("R6 empty mask ones", vec_c, 8'h81);
        apply(64'h0, 4'b0000, 1'b1);
        check("R6 empty mask zero", vec_c, 8'h81);

        // R7 unselected lanes ignored
        w = make_word(2, 0, 3, 0);
        apply(w, 4'b1010, 1'b1);
        first = vec_c;
        apply(w ^ 64'h00ff_00ff_0000_0000, 4'b1010, 1'b1);
        check("R7 unselected flip", vec_c, first);

        // Directed stop and step-ready groups
        apply(make_word(2, 2, 2, 2), 4'b1111, 1'b1);
        apply(make_word(3, 3, 3, 3), 4'b1111, 1'b1);
        apply(make_word(3, 2, 1, 4), 4'b0110, 1'b1);
        apply(make_word(1, 1, 1, 1), 4'b1111, 1'b1);
        apply(make_word(4, 4, 1, 1), 4'b1100, 1'b0);
        apply(make_word(3, 3, 0, 0), 4'b1100, 1'b0);

        // Biased random traffic with idle cycles
        for (int k = 0; k < 400; k++) begin
            apply(make_word($urandom_range(0, 4), $urandom_range(0, 4),
                            $urandom_range(0, 4), $urandom_range(0, 4)),
                  4'($urandom), ($urandom_range(0, 3) != 0));
        end

        apply(64'h0, 4'b0000, 1'b0);
        apply(64'h0, 4'b0000, 1'b0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule